// File: doc/BRIEF.md
# Digital Phase-Tracking Loop Filter for an Interpolator-Based Clock Recovery Receiver

This block is the digital core of a clock and data recovery receiver whose sampling clock comes out of a phase interpolator. A bang-bang phase detector reports, on each update cycle, only whether the sampling clock is ahead of or behind the data. It gives a direction and no magnitude. The block runs that decision through a proportional path and a saturating integral path, and adds their sum to a phase position.

The phase position is split into two outputs for the interpolator. The coarse select names the pair of adjacent quadrature clock phases being mixed. The fine code sets the weight between them, and runs from 0 to 30, so one quadrant holds 31 steps of about 2.9° each. When the fine position passes either end of its range, it wraps into the neighbouring pair and the coarse select moves by one. The sampling phase therefore turns through the full clock period with no jump.

The proportional gain, the integral gain and the integrator limit are run-time inputs. A configuration bit chooses how the fine code is delivered: directly, or through a computed sinusoidal-compensation table.

Top module: `cdrlf_track_loop`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears the integrator and the phase position. After that edge, `sel_o` is 0 and the fine position is 0, and updates with no decision leave the phase at 0.
- R2: The decision is +1 when only `early_i` is high and -1 when only `late_i` is high. When both or neither are high, the decision is 0 and only the integrator value is added to the phase.
- R3: On each accepted update, the integrator becomes its old value plus decision times `ki_i`. The result is clamped to the range [-`int_lim_i`, +`int_lim_i`] and never wraps.
- R4: On each accepted update, the phase advances by decision times `kp_i` plus the new integrator value. The units are 1/16 of a fine step (FRAC_W=4). The step is clamped to ±495, which is one quadrant (31·16) minus one.
- R5: The fine position runs from 0 to 30. Passing above 30 wraps to 0 and increments `sel_o`. Passing below 0 wraps to 30 and decrements `sel_o`. `sel_o` wraps modulo 4. The whole phase is therefore `sel_o`·496 + fine·16 + fraction, taken modulo 1984.
- R6: While `hold_i` is high, the integrator and the phase are frozen, even when `upd_i` and a decision are present.
- R7: While `upd_i` is low, the integrator and the phase are frozen.
- R8: With `sin_map_i` = 0, `fine_o` equals the fine position.
- R9: With `sin_map_i` = 1, `fine_o` is within 1 of 31·sin θ/(sin θ + cos θ), where θ = 90°·fine/31. It is 0 at fine position 0 and does not decrease as the fine position rises through the quadrant.
- R10: An update sampled at a clock edge shows on `sel_o` and `fine_o` after that edge and not before. This is one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Update clock |
| rst_i | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | An update is presented this cycle |
| early_i | input | 1 | Phase detector: sampling is early, advance the phase |
| late_i | input | 1 | Phase detector: sampling is late, retard the phase |
| hold_i | input | 1 | Freeze the integrator and the phase |
| kp_i | input | KP_W (8) | Proportional gain, in 1/16 fine steps |
| ki_i | input | KI_W (6) | Integral gain, in 1/16 fine steps |
| int_lim_i | input | INT_W-1 (11) | Integrator magnitude limit |
| sin_map_i | input | 1 | 1: sinusoidal fine code, 0: linear fine code |
| sel_o | output | SEL_W (2) | Coarse select of the interpolator phase pair |
| fine_o | output | FINE_W (5) | Fine interpolator weight code |

## Verification
The hardest situation to reach from the ports is a phase step clamped at a full quadrant while the integrator sits at its limit. The integrator can only get there after many same-direction decisions at maximum integral gain with a large limit. The bench drives that sequence on purpose and then follows the phase as it crosses several coarse boundaries in both directions. Random stretches with gains, limits and mapping changed every 64 cycles, and occasional holds, idle cycles and resets, also cover changes of limit while the integrator is above the new bound.

// File: rtl/cdrlf_pkg.sv
`timescale 1ns/1ps
package cdrlf_pkg;

   // Weight on the later phase that places the interpolated edge at
   // 90deg*f/steps, using an integer rational sine approximation.
   function automatic int sin_weight(input int f, input int steps);
      longint d_s, d_c, n_s, n_c, s_v, c_v, den, half;
      if (f <= 0) return 0;
      if (f >= steps) return steps;
      half = longint'(180) * steps;
      d_s  = longint'(90) * f;
      d_c  = longint'(90) * (steps - f);
      n_s  = d_s * (half - d_s);
      n_c  = d_c * (half - d_c);
      den  = longint'(40500) * steps * steps;
      s_v  = (longint'(4) * n_s * 65536) / (den - n_s);
      c_v  = (longint'(4) * n_c * 65536) / (den - n_c);
      return int'((longint'(2) * steps * s_v + s_v + c_v) / (longint'(2) * (s_v + c_v)));
   endfunction

endpackage

// File: rtl/cdrlf_pi_filter.sv
`timescale 1ns/1ps
module cdrlf_pi_filter #(
   parameter int KP_W    = 8,
   parameter int KI_W    = 6,
   parameter int INT_W   = 12,
   parameter int DELTA_W = 10,
   parameter int QSPAN   = 496
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      en_i,
   input  logic                      early_i,
   input  logic                      late_i,
   input  logic [KP_W-1:0]           kp_i,
   input  logic [KI_W-1:0]           ki_i,
   input  logic [INT_W-2:0]          lim_i,
   output logic signed [INT_W-1:0]   integ_o,
   output logic signed [DELTA_W-1:0] delta_o
);
   localparam int SW = INT_W + 2;
   localparam int PW = ((KP_W > INT_W) ? KP_W : INT_W) + 3;
   localparam logic signed [PW-1:0] DMAX = PW'(QSPAN - 1);

   logic signed [1:0]    dir;
   logic signed [SW-1:0] ki_s, lim_s, isum, inext;
   logic signed [PW-1:0] kp_s, prop, raw, lim_d;

   always_comb begin
      dir = 2'sb00;
      if (early_i && !late_i)      dir = 2'sb01;
      else if (late_i && !early_i) dir = 2'sb11;
   end

   always_comb begin
      ki_s  = $signed(SW'(ki_i));
      lim_s = $signed(SW'(lim_i));
      unique case (dir)
         2'sb01:  isum = SW'(integ_o) + ki_s;
         2'sb11:  isum = SW'(integ_o) - ki_s;
         default: isum = SW'(integ_o);
      endcase
      if (isum > lim_s)       inext = lim_s;
      else if (isum < -lim_s) inext = -lim_s;
      else                    inext = isum;
   end

   always_comb begin
      kp_s = $signed(PW'(kp_i));
      unique case (dir)
         2'sb01:  prop = kp_s;
         2'sb11:  prop = -kp_s;
         default: prop = '0;
      endcase
      raw = prop + PW'(inext);
      if (raw > DMAX)       lim_d = DMAX;
      else if (raw < -DMAX) lim_d = -DMAX;
      else                  lim_d = raw;
      delta_o = DELTA_W'(lim_d);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)     integ_o <= '0;
      else if (en_i) integ_o <= INT_W'(inext);
   end
endmodule

// File: rtl/cdrlf_phase_acc.sv
`timescale 1ns/1ps
module cdrlf_phase_acc #(
   parameter int SEL_W   = 2,
   parameter int POS_W   = 9,
   parameter int DELTA_W = 10,
   parameter int QSPAN   = 496
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      en_i,
   input  logic signed [DELTA_W-1:0] delta_i,
   output logic [SEL_W-1:0]          sel_o,
   output logic [POS_W-1:0]          pos_o
);
   localparam int TW = ((POS_W > DELTA_W) ? POS_W : DELTA_W) + 2;
   localparam logic signed [TW-1:0] SPAN = TW'(QSPAN);

   logic signed [TW-1:0] tot, wrapped;
   logic signed [1:0]    carry;

   always_comb begin
      tot = $signed(TW'(pos_o)) + TW'(delta_i);
      if (tot >= SPAN) begin
         wrapped = tot - SPAN;
         carry   = 2'sb01;
      end else if (tot < 0) begin
         wrapped = tot + SPAN;
         carry   = 2'sb11;
      end else begin
         wrapped = tot;
         carry   = 2'sb00;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sel_o <= '0;
         pos_o <= '0;
      end else if (en_i) begin
         sel_o <= sel_o + SEL_W'(carry);
         pos_o <= POS_W'(wrapped);
      end
   end
endmodule

// File: rtl/cdrlf_code_map.sv
`timescale 1ns/1ps
module cdrlf_code_map #(
   parameter int FINE_W  = 5,
   parameter int STEPS   = 31,
   parameter bit SIN_LUT = 1'b1
) (
   input  logic [FINE_W-1:0] fine_i,
   input  logic              sin_i,
   output logic [FINE_W-1:0] code_o
);
   localparam int NCODE = 1 << FINE_W;

   generate
      if (SIN_LUT) begin : g_sin
         logic [FINE_W-1:0] lut [NCODE];
         for (genvar g = 0; g < NCODE; g++) begin : g_ent
            localparam int WGT = cdrlf_pkg::sin_weight(g, STEPS);
            assign lut[g] = FINE_W'(WGT);
         end
         assign code_o = sin_i ? lut[fine_i] : fine_i;
      end else begin : g_lin
         logic unused_sin;
         assign unused_sin = sin_i;
         assign code_o     = fine_i;
      end
   endgenerate
endmodule

// File: rtl/cdrlf_track_loop.sv
`timescale 1ns/1ps
module cdrlf_track_loop #(
   parameter int SEL_W   = 2,
   parameter int FINE_W  = 5,
   parameter int FRAC_W  = 4,
   parameter int KP_W    = 8,
   parameter int KI_W    = 6,
   parameter int INT_W   = 12,
   parameter bit SIN_LUT = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              upd_i,
   input  logic              early_i,
   input  logic              late_i,
   input  logic              hold_i,
   input  logic [KP_W-1:0]   kp_i,
   input  logic [KI_W-1:0]   ki_i,
   input  logic [INT_W-2:0]  int_lim_i,
   input  logic              sin_map_i,
   output logic [SEL_W-1:0]  sel_o,
   output logic [FINE_W-1:0] fine_o
);
   localparam int STEPS   = (1 << FINE_W) - 1;
   localparam int QSPAN   = STEPS << FRAC_W;
   localparam int POS_W   = FINE_W + FRAC_W;
   localparam int DELTA_W = POS_W + 1;

   if (SEL_W < 1)       begin : g_bad_sel  $error("SEL_W must be at least 1"); end
   if (FINE_W < 2)      begin : g_bad_fine $error("FINE_W must be at least 2"); end
   if (FRAC_W < 1)      begin : g_bad_frac $error("FRAC_W must be at least 1"); end
   if (KI_W >= INT_W)   begin : g_bad_ki   $error("KI_W must be below INT_W"); end

   logic                      upd_en;
   logic signed [DELTA_W-1:0] delta;
   logic signed [INT_W-1:0]   integ_unused;
   logic [POS_W-1:0]          pos;
   logic [FINE_W-1:0]         fine_idx;
   logic [FRAC_W-1:0]         unused_frac;

   assign upd_en      = upd_i && !hold_i;
   assign fine_idx    = pos[POS_W-1:FRAC_W];
   assign unused_frac = pos[FRAC_W-1:0];

   cdrlf_pi_filter #(
      .KP_W(KP_W), .KI_W(KI_W), .INT_W(INT_W), .DELTA_W(DELTA_W), .QSPAN(QSPAN)
   ) filt_i (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(upd_en),
      .early_i(early_i), .late_i(late_i),
      .kp_i(kp_i), .ki_i(ki_i), .lim_i(int_lim_i),
      .integ_o(integ_unused), .delta_o(delta)
   );

   cdrlf_phase_acc #(
      .SEL_W(SEL_W), .POS_W(POS_W), .DELTA_W(DELTA_W), .QSPAN(QSPAN)
   ) acc_i (
      .clk_i(clk_i), .rst_i(rst_i), .en_i(upd_en),
      .delta_i(delta), .sel_o(sel_o), .pos_o(pos)
   );

   cdrlf_code_map #(
      .FINE_W(FINE_W), .STEPS(STEPS), .SIN_LUT(SIN_LUT)
   ) map_i (
      .fine_i(fine_idx), .sin_i(sin_map_i), .code_o(fine_o)
   );
endmodule

// File: rtl/cdrlf_track_loop_chk.sv
`timescale 1ns/1ps
module cdrlf_track_loop_chk #(
   parameter int SEL_W  = 2,
   parameter int FINE_W = 5,
   parameter int INT_W  = 12
) (
   input logic                    clk_i,
   input logic                    rst_i,
   input logic                    upd_i,
   input logic                    hold_i,
   input logic [INT_W-2:0]        int_lim_i,
   input logic [SEL_W-1:0]        sel_o,
   input logic [FINE_W-1:0]       fine_idx,
   input logic signed [INT_W-1:0] integ
);
   localparam logic [FINE_W-1:0] FINE_TOP = FINE_W'((1 << FINE_W) - 2);

   logic rst_d;
   always_ff @(posedge clk_i) rst_d <= rst_i;

   always_ff @(posedge clk_i) begin
      if (rst_d) begin
         AST_RESET_CLEAR: assert (sel_o == '0 && fine_idx == '0 && integ == '0) // R1
            else $error("state not cleared by reset");
      end
   end

   AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i) hold_i |=> ($stable(sel_o) && $stable(fine_idx) && $stable(integ))) else $error("hold did not freeze"); // R6
   AST_IDLE_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i) !upd_i |=> ($stable(sel_o) && $stable(fine_idx) && $stable(integ))) else $error("idle cycle changed state"); // R7
   AST_INT_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i) (upd_i && !hold_i) |=> (integ <= $signed({1'b0, $past(int_lim_i)}) && integ >= -$signed({1'b0, $past(int_lim_i)}))) else $error("integrator beyond limit"); // R3
   AST_FINE_RANGE: assert property (@(posedge clk_i) disable iff (rst_i) (upd_i && !hold_i) |=> (fine_idx <= FINE_TOP)) else $error("fine position out of range"); // R5
   AST_SEL_ONE_STEP: assert property (@(posedge clk_i) disable iff (rst_i) (upd_i && !hold_i) |=> (sel_o == $past(sel_o) || sel_o == SEL_W'($past(sel_o) + 1'b1) || sel_o == SEL_W'($past(sel_o) - 1'b1))) else $error("coarse select jumped"); // R5
endmodule

bind cdrlf_track_loop cdrlf_track_loop_chk #(
   .SEL_W(SEL_W), .FINE_W(FINE_W), .INT_W(INT_W)
) chk_i (
   .clk_i(clk_i), .rst_i(rst_i), .upd_i(upd_i), .hold_i(hold_i),
   .int_lim_i(int_lim_i), .sel_o(sel_o), .fine_idx(fine_idx), .integ(integ_unused)
);

// File: tb/cdrlf_track_loop_tb_top.sv
`timescale 1ns/1ps
module cdrlf_track_loop_tb_top;
   localparam int SEL_W = 2, FINE_W = 5, FRAC_W = 4, KP_W = 8, KI_W = 6, INT_W = 12;
   localparam int STEPS = (1 << FINE_W) - 1;
   localparam int QSPAN = STEPS << FRAC_W;
   localparam int FULL  = QSPAN * (1 << SEL_W);

   logic clk = 1'b0;
   logic rst_i = 1'b1, upd_i = 1'b0, early_i = 1'b0, late_i = 1'b0, hold_i = 1'b0, sin_map_i = 1'b0;
   logic [KP_W-1:0]   kp_i = '0;
   logic [KI_W-1:0]   ki_i = '0;
   logic [INT_W-2:0]  int_lim_i = '0;
   logic [SEL_W-1:0]  sel_o;
   logic [FINE_W-1:0] fine_o;

   always #10 clk = ~clk;

   cdrlf_track_loop dut_i (
      .clk_i(clk), .rst_i(rst_i), .upd_i(upd_i), .early_i(early_i), .late_i(late_i),
      .hold_i(hold_i), .kp_i(kp_i), .ki_i(ki_i), .int_lim_i(int_lim_i),
      .sin_map_i(sin_map_i), .sel_o(sel_o), .fine_o(fine_o)
   );

   int n_chk = 0, n_err = 0;
   int m_int = 0, m_pos = 0;
   bit done = 1'b0;

   function automatic int clampi(input int v, input int lo, input int hi);
      return (v > hi) ? hi : ((v < lo) ? lo : v);
   endfunction

   function automatic real sin_ref(input int f);
      real th;
      th = 3.14159265358979 * f / (2.0 * STEPS);
      return STEPS * $sin(th) / ($sin(th) + $cos(th));
   endfunction

   task automatic model_step();
      int d, dl;
      if (rst_i) begin
         m_int = 0;
         m_pos = 0;
      end else if (upd_i && !hold_i) begin
         d = (early_i && !late_i) ? 1 : ((late_i && !early_i) ? -1 : 0);
         m_int = clampi(m_int + d * int'(ki_i), -int'(int_lim_i), int'(int_lim_i));
         dl = clampi(d * int'(kp_i) + m_int, -(QSPAN - 1), QSPAN - 1);
         m_pos = (m_pos + dl + FULL) % FULL;
      end
   endtask

   task automatic check_out(input string tag);
      int  es, ef;
      real diff;
      es = m_pos / QSPAN;
      ef = (m_pos % QSPAN) >> FRAC_W;
      n_chk++;
      if (int'(sel_o) != es) begin
         n_err++;
         $display("FAIL %s: sel actual %0d expected %0d", tag, sel_o, es);
      end
      n_chk++;
      if (!sin_map_i) begin
         if (int'(fine_o) != ef) begin
            n_err++;
            $display("FAIL %s: fine actual %0d expected %0d", tag, fine_o, ef);
         end
      end else begin
         diff = real'(fine_o) - sin_ref(ef);
         if (diff > 1.0 || diff < -1.0) begin
            n_err++;
            $display("FAIL %s: mapped fine actual %0d expected %f", tag, fine_o, sin_ref(ef));
         end
      end
   endtask

   task automatic cyc(input bit r, input bit e, input bit l, input bit u, input bit h, input string tag);
      rst_i = r; early_i = e; late_i = l; upd_i = u; hold_i = h;
      @(negedge clk);
      model_step();
      check_out(tag);
   endtask

   initial begin
      int prev;
      void'($urandom(32'h1c3d_5a7b));
      kp_i = 8'd16;
      @(negedge clk); @(negedge clk);
      cyc(1, 0, 0, 0, 0, "R1");
      rst_i = 1'b0;
      check_out("R1");

      // R10: new decision visible only after the edge
      early_i = 1'b1; upd_i = 1'b1;
      #5;
      n_chk++;
      if (sel_o !== '0 || fine_o !== '0) begin
         n_err++;
         $display("FAIL R10: before edge actual %0d/%0d expected 0/0", sel_o, fine_o);
      end
      @(negedge clk); model_step(); check_out("R10");

      // R2: decode of the two decision inputs
      cyc(0, 0, 1, 1, 0, "R2");
      cyc(0, 1, 0, 1, 0, "R2");
      cyc(0, 1, 1, 1, 0, "R2");
      cyc(0, 0, 0, 1, 0, "R2");
      n_chk++;
      if (fine_o !== 5'd1) begin
         n_err++;
         $display("FAIL R2: fine actual %0d expected 1", fine_o);
      end

      // R1: after reset the integrator is empty, neutral updates do not move
      ki_i = 6'd20; int_lim_i = 11'd300;
      for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 0, "R3");
      cyc(1, 0, 0, 1, 0, "R1");
      kp_i = '0;
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0, "R1");

      // R5: crossing coarse boundaries upward and downward
      kp_i = 8'd255; ki_i = '0;
      for (int i = 0; i < 20; i++) cyc(0, 1, 0, 1, 0, "R5");
      for (int i = 0; i < 45; i++) cyc(0, 0, 1, 1, 0, "R5");

      // R3: integrator saturation and constant drift
      cyc(1, 0, 0, 0, 0, "R1");
      kp_i = '0; ki_i = 6'd63; int_lim_i = 11'd100;
      for (int i = 0; i < 5; i++)  cyc(0, 1, 0, 1, 0, "R3");
      for (int i = 0; i < 5; i++)  cyc(0, 0, 0, 1, 0, "R3");
      for (int i = 0; i < 10; i++) cyc(0, 0, 1, 1, 0, "R3");
      for (int i = 0; i < 5; i++)  cyc(0, 1, 1, 1, 0, "R3");

      // R4: phase step clamped at one quadrant with a full integrator
      cyc(1, 0, 0, 0, 0, "R1");
      kp_i = 8'd255; ki_i = 6'd63; int_lim_i = 11'd2047;
      for (int i = 0; i < 45; i++) cyc(0, 1, 0, 1, 0, "R4");
      for (int i = 0; i < 90; i++) cyc(0, 0, 1, 1, 0, "R4");

      // R6 / R7: hold and idle freeze state
      for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, 1, "R6");
      for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0, "R7");

      // R9 / R8: sweep the whole quadrant with the sinusoidal table
      cyc(1, 0, 0, 0, 0, "R1");
      kp_i = 8'd16; ki_i = '0; sin_map_i = 1'b1;
      #1;
      check_out("R9");
      prev = int'(fine_o);
      for (int i = 0; i < STEPS - 1; i++) begin
         cyc(0, 1, 0, 1, 0, "R9");
         n_chk++;
         if (int'(fine_o) < prev) begin
            n_err++;
            $display("FAIL R9: code actual %0d expected at least %0d", fine_o, prev);
         end
         prev = int'(fine_o);
      end
      sin_map_i = 1'b0;
      #1;
      check_out("R8");
      cyc(0, 1, 0, 1, 0, "R5");

      // random stretches
      for (int i = 0; i < 3000; i++) begin
         bit r, e, l, u, h;
         string tag;
         if (i % 64 == 0) begin
            kp_i = KP_W'($urandom);
            ki_i = KI_W'($urandom);
            int_lim_i = (INT_W-1)'($urandom % 2048);
            sin_map_i = 1'($urandom);
         end
         r = ($urandom % 500) == 0;
         e = 1'($urandom); l = 1'($urandom);
         u = ($urandom % 10) != 0;
         h = ($urandom % 10) == 0;
         tag = r ? "R1" : (!u ? "R7" : (h ? "R6" : (sin_map_i ? "R9" : "R4")));
         cyc(r, e, l, u, h, tag);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule